// File: doc/BRIEF.md
# Temporal Frame-Modulation Dither

This block lowers the bit depth of a multi-channel pixel stream while keeping part of the lost precision visible over time. The discarded low bits of each component carry a fractional grey level. The block rounds that fraction to a quarter step and then raises the kept value by one LSB in a matching share of frames: one frame in four, two in four, or three in four. A viewer averaging over frames sees a level close to the original. Which frames are raised depends on a small built-in pattern per quarter level and on a phase. The phase mixes a 2-bit frame counter with the parity of the pixel's column and row, so neighbouring pixels do not flicker together.

Configuration is given as a set of fields together with a one-cycle load strobe. A control state machine has three states: OFF, CLEAR and RUN. Three transitions connect them. LOAD goes from any state to CLEAR. In CLEAR every active setting is zero, and the fields given with the strobe are captured. APPLY_ON goes from CLEAR to RUN when dithering was enabled at a supported depth. APPLY_OFF goes from CLEAR to OFF in every other case. Outside RUN the block only truncates. The 10-bit target cannot be dithered: asking for it leaves the block truncating. Pixel results are registered and appear one cycle after the pixel is presented.

Top module: `frc_dither`

## Requirements
- R1: After reset the block is in OFF with all active settings zero. A valid pixel is returned one cycle later, truncated to 6 bits: the low 6 bits of each 12-bit component are cleared, so 0xABC becomes 0xA80.
- R2: A load strobe clears every active setting for exactly one cycle. This covers hold, phase offset, depth, span and the three selects. A pixel presented in that CLEAR cycle is truncated to 6 bits, for example 0x12C gives 0x100. On the next edge the captured fields take effect.
- R3: The depth code sets the kept bits: 0 keeps 6, 1 keeps 8, 2 or 3 keeps 10. With depth code 2 or 3, or with enable low, the state after CLEAR is OFF. The output is then plain truncation at that depth, for example 0x7FF gives 0x7FC at depth 2, in every frame.
- R4: The span field sets how many discarded bits are used. With span 1, the top two discarded bits form the quarter count q (0 to 3). With span 0, only the top discarded bit is used, giving q = 0 or 2.
- R5: In RUN the kept value is raised by one when the pattern bit at the current phase is set. For q=1 the pattern is one-hot at position sel_q1. For q=2, sel_q2 values 0, 1, 2 and 3 give the bit masks 0101, 1010, 0011 and 1100, where bit p is phase p. For q=3 the pattern is all ones except position sel_q3. For q=0 the value is never raised.
- R6: The phase is ((frame counter + offset) mod 4) XOR {row_lsb, col_lsb}.
- R7: While the active hold field is 1, the frame counter is held at 0. Otherwise it steps by one, modulo 4, on each start-of-frame pulse. A pixel in the same cycle as the pulse uses the old count.
- R8: A raise never wraps. A kept value already at its maximum stays there, so 0xFFF at depth 0 gives 0xFC0.
- R9: Over any 4 consecutive frames, the sum of a pixel's kept values equals 4 times its truncated value plus q, except when the truncated value is already at its maximum.
- R10: out_valid equals pix_valid delayed by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | One-cycle strobe that captures the configuration fields |
| cfg_en | input | 1 | Requests dithering |
| cfg_hold | input | 1 | Holds the frame counter at zero |
| cfg_phase_ofs | input | 2 | Offset added to the frame counter |
| cfg_depth | input | 2 | Target depth code (0: 6, 1: 8, 2/3: 10 bits) |
| cfg_span | input | 1 | 0: one discarded bit modulated, 1: two bits |
| cfg_sel_q1 | input | 2 | Pattern select for the quarter level |
| cfg_sel_q2 | input | 2 | Pattern select for the half level |
| cfg_sel_q3 | input | 2 | Pattern select for the three-quarter level |
| sof | input | 1 | Start-of-frame pulse |
| pix_valid | input | 1 | Pixel present |
| pix_col_lsb | input | 1 | Least significant bit of the column index |
| pix_row_lsb | input | 1 | Least significant bit of the row index |
| pix_in | input | NUM_CH*IN_W | Input components, channel 0 in the low bits |
| out_valid | output | 1 | Output pixel present |
| pix_out | output | NUM_CH*IN_W | Reduced components, left-aligned, low bits zero |

## Verification
A pixel's result and its valid flag are due one edge after the pixel is presented. A load strobe shows its cleared settings at the first edge and its new settings at the second. A start-of-frame pulse changes the phase from the following edge. The bench drives inputs on the falling edge and runs a behavioural model on each rising edge, using the pre-edge inputs and its own state. It compares the registered outputs at the next falling edge, which is where each of these results is due. Directed checks repeat that one-edge spacing: they present a pixel and read it back one edge later. The four-frame mean checks add one pulse edge before each pixel.

// File: rtl/frc_dither_pkg.sv
package frc_dither_pkg;

    localparam int PH_W       = 2;
    localparam int DEPTH_STEP = 2;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_CLEAR = 2'd1,
        ST_RUN   = 2'd2
    } frc_state_e;

    typedef struct packed {
        logic            hold;
        logic [PH_W-1:0] ofs;
        logic [1:0]      depth;
        logic            span;
        logic [1:0]      sel_q1;
        logic [1:0]      sel_q2;
        logic [1:0]      sel_q3;
    } frc_cfg_t;

    // Number of bits kept for a depth code.
    function automatic int kept_bits(input logic [1:0] depth, input int base_w);
        int k;
        unique case (depth)
            2'd0:    k = base_w;
            2'd1:    k = base_w + DEPTH_STEP;
            default: k = base_w + 2 * DEPTH_STEP;
        endcase
        return k;
    endfunction

    // Four-phase on/off mask for a quarter count; bit p is phase p.
    function automatic logic [3:0] level_mask(input logic [1:0] q,
                                              input logic [1:0] s1,
                                              input logic [1:0] s2,
                                              input logic [1:0] s3);
        logic [3:0] m;
        unique case (q)
            2'd0: m = 4'b0000;
            2'd1: m = 4'b0001 << s1;
            2'd2: begin
                unique case (s2)
                    2'd0: m = 4'b0101;
                    2'd1: m = 4'b1010;
                    2'd2: m = 4'b0011;
                    2'd3: m = 4'b1100;
                endcase
            end
            2'd3: m = ~(4'b0001 << s3);
        endcase
        return m;
    endfunction

endpackage

// File: rtl/frc_dither_ctrl.sv
module frc_dither_ctrl
    import frc_dither_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load,
    input  logic     new_en,
    input  frc_cfg_t new_cfg,
    output logic     run,
    output frc_cfg_t act_cfg
);

    frc_state_e state_q, state_d;
    frc_cfg_t   sh_cfg;
    logic       sh_en;
    logic       sh_ok;

    assign sh_ok = sh_en && !sh_cfg.depth[1];

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF, ST_RUN: begin
                if (load) state_d = ST_CLEAR;                   // LOAD
            end
            ST_CLEAR: begin
                if (load)       state_d = ST_CLEAR;             // LOAD
                else if (sh_ok) state_d = ST_RUN;               // APPLY_ON
                else            state_d = ST_OFF;               // APPLY_OFF
            end
            default: state_d = ST_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Configuration outputs: clear on load, apply in CLEAR
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_cfg  <= '0;
            sh_en   <= 1'b0;
            act_cfg <= '0;
        end else if (load) begin
            sh_cfg  <= new_cfg;
            sh_en   <= new_en;
            act_cfg <= '0;
        end else if (state_q == ST_CLEAR) begin
            act_cfg <= sh_cfg;
        end
    end

    assign run = (state_q == ST_RUN);

    // R2: a load always lands in CLEAR with every setting zero
    a_r2_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (state_q == ST_CLEAR) && (act_cfg == '0));

    // R2: CLEAR lasts one cycle unless another load arrives
    a_r2_clear_short: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CLEAR && !load) |=> (state_q != ST_CLEAR));

    // R3: disabled or 10-bit request ends in OFF
    a_r3_refuse: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CLEAR && !load && (!sh_en || sh_cfg.depth[1])) |=> (state_q == ST_OFF));

    // R3: never dither at the 10-bit depth
    a_r3_run_depth: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> !act_cfg.depth[1]);

endmodule

// File: rtl/frc_dither_phase.sv
module frc_dither_phase
    import frc_dither_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hold,
    input  logic            sof,
    input  logic [PH_W-1:0] ofs,
    input  logic            col_lsb,
    input  logic            row_lsb,
    output logic [PH_W-1:0] phase
);

    logic [PH_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (hold) cnt <= '0;
        else if (sof)  cnt <= cnt + 1'b1;
    end

    assign phase = (cnt + ofs) ^ {row_lsb, col_lsb};

    // R7: hold forces the counter to zero
    a_r7_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (cnt == '0));

    // R7: one step per frame pulse
    a_r7_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && sof) |=> (cnt == $past(cnt) + 1'b1));

    // R7: no pulse, no movement
    a_r7_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !sof) |=> $stable(cnt));

endmodule

// File: rtl/frc_dither_lane.sv
module frc_dither_lane
    import frc_dither_pkg::*;
#(
    parameter int IN_W   = 12,
    parameter int BASE_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [1:0]      depth,
    input  logic            span,
    input  logic [1:0]      sel_q1,
    input  logic [1:0]      sel_q2,
    input  logic [1:0]      sel_q3,
    input  logic [PH_W-1:0] phase,
    input  logic [IN_W-1:0] din,
    output logic [IN_W-1:0] dout
);

    int              kb;
    int              drop;
    logic [IN_W-1:0] trunc, top_v, sum, floor_v, dnext;
    logic [1:0]      rem2, q;
    logic [3:0]      mask;
    logic            bump;

    always_comb begin
        kb      = kept_bits(depth, BASE_W);
        drop    = IN_W - kb;
        trunc   = din >> drop;
        floor_v = trunc << drop;
        rem2    = 2'(din >> (drop - 2));
        q       = span ? rem2 : {rem2[1], 1'b0};
        mask    = level_mask(q, sel_q1, sel_q2, sel_q3);
        bump    = run && mask[phase];
        top_v   = IN_W'((1 << kb) - 1);
        sum     = (bump && (trunc != top_v)) ? trunc + 1'b1 : trunc;
        dnext   = sum << drop;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dout <= '0;
        else        dout <= dnext;
    end

    // R8: the output never falls below the truncated input
    a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (dout >= $past(floor_v)));

    // R3: outside RUN the output is plain truncation
    a_r3_off_trunc: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (dout == $past(floor_v)));

endmodule

// File: rtl/frc_dither.sv
module frc_dither
    import frc_dither_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int IN_W   = 12,
    parameter int BASE_W = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_load,
    input  logic                   cfg_en,
    input  logic                   cfg_hold,
    input  logic [1:0]             cfg_phase_ofs,
    input  logic [1:0]             cfg_depth,
    input  logic                   cfg_span,
    input  logic [1:0]             cfg_sel_q1,
    input  logic [1:0]             cfg_sel_q2,
    input  logic [1:0]             cfg_sel_q3,
    input  logic                   sof,
    input  logic                   pix_valid,
    input  logic                   pix_col_lsb,
    input  logic                   pix_row_lsb,
    input  logic [NUM_CH*IN_W-1:0] pix_in,
    output logic                   out_valid,
    output logic [NUM_CH*IN_W-1:0] pix_out
);

    frc_cfg_t        new_cfg;
    frc_cfg_t        act_cfg;
    logic            run;
    logic [PH_W-1:0] phase;

    always_comb begin
        new_cfg.hold   = cfg_hold;
        new_cfg.ofs    = cfg_phase_ofs;
        new_cfg.depth  = cfg_depth;
        new_cfg.span   = cfg_span;
        new_cfg.sel_q1 = cfg_sel_q1;
        new_cfg.sel_q2 = cfg_sel_q2;
        new_cfg.sel_q3 = cfg_sel_q3;
    end

    frc_dither_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cfg_load),
        .new_en  (cfg_en),
        .new_cfg (new_cfg),
        .run     (run),
        .act_cfg (act_cfg)
    );

    frc_dither_phase u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (act_cfg.hold),
        .sof     (sof),
        .ofs     (act_cfg.ofs),
        .col_lsb (pix_col_lsb),
        .row_lsb (pix_row_lsb),
        .phase   (phase)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
        frc_dither_lane #(
            .IN_W   (IN_W),
            .BASE_W (BASE_W)
        ) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (run),
            .depth  (act_cfg.depth),
            .span   (act_cfg.span),
            .sel_q1 (act_cfg.sel_q1),
            .sel_q2 (act_cfg.sel_q2),
            .sel_q3 (act_cfg.sel_q3),
            .phase  (phase),
            .din    (pix_in[g*IN_W +: IN_W]),
            .dout   (pix_out[g*IN_W +: IN_W])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= pix_valid;
    end

    // R10: valid follows the input by one cycle
    a_r10_valid_on: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> out_valid);

    a_r10_valid_off: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> !out_valid);

endmodule

// File: tb/sim_frc_dither.sv
module sim_frc_dither;

    localparam int NCH = 3;
    localparam int W   = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_load = 0, cfg_en = 0, cfg_hold = 0, cfg_span = 0;
    logic [1:0] cfg_ofs = 0, cfg_depth = 0, s1 = 0, s2 = 0, s3 = 0;
    logic sof = 0, pix_valid = 0, col = 0, row = 0;
    logic [NCH*W-1:0] pix_in = '0;
    logic out_valid;
    logic [NCH*W-1:0] pix_out;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    frc_dither u0 (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_en(cfg_en),
        .cfg_hold(cfg_hold), .cfg_phase_ofs(cfg_ofs), .cfg_depth(cfg_depth),
        .cfg_span(cfg_span), .cfg_sel_q1(s1), .cfg_sel_q2(s2), .cfg_sel_q3(s3),
        .sof(sof), .pix_valid(pix_valid), .pix_col_lsb(col), .pix_row_lsb(row),
        .pix_in(pix_in), .out_valid(out_valid), .pix_out(pix_out)
    );

    task automatic chk(input string rq, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_st = 0;                 // 0 off, 1 clear, 2 run
    int a_hold = 0, a_ofs = 0, a_dep = 0, a_span = 0, a_s1 = 0, a_s2 = 0, a_s3 = 0;
    int h_hold = 0, h_ofs = 0, h_dep = 0, h_span = 0, h_s1 = 0, h_s2 = 0, h_s3 = 0, h_en = 0;
    int m_cnt = 0;
    logic exp_v = 0;
    int exp_d [NCH];
    string exp_tag = "R1";

    function automatic int mdl_out(int v, int c, int r);
        int k, d, t, rem2, q, ph;
        bit on;
        k = (a_dep == 0) ? 6 : (a_dep == 1) ? 8 : 10;
        d = W - k;
        t = v >> d;
        if (m_st != 2) return t << d;
        rem2 = (v >> (d - 2)) & 3;
        q = a_span ? rem2 : (rem2 & 2);
        ph = ((m_cnt + a_ofs) % 4) ^ (r * 2 + c);
        case (q)
            1: on = (ph == a_s1);
            2: on = (a_s2 == 0) ? (ph % 2 == 0) : (a_s2 == 1) ? (ph % 2 == 1) :
                    (a_s2 == 2) ? (ph < 2) : (ph >= 2);
            3: on = (ph != a_s3);
            default: on = 0;
        endcase
        if (on && t < (1 << k) - 1) t++;
        return t << d;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; exp_v = 0;
            a_hold = 0; a_ofs = 0; a_dep = 0; a_span = 0; a_s1 = 0; a_s2 = 0; a_s3 = 0;
        end else begin
            exp_v = pix_valid;
            exp_tag = (m_st == 2) ? "R5" : (m_st == 1) ? "R2" : "R3";
            for (int ch = 0; ch < NCH; ch++)
                exp_d[ch] = mdl_out(int'(pix_in[ch*W +: W]), int'(col), int'(row));
            if (a_hold != 0) m_cnt = 0;
            else if (sof)    m_cnt = (m_cnt + 1) % 4;
            if (cfg_load) begin
                h_hold = cfg_hold; h_ofs = cfg_ofs; h_dep = cfg_depth; h_span = cfg_span;
                h_s1 = s1; h_s2 = s2; h_s3 = s3; h_en = cfg_en;
                a_hold = 0; a_ofs = 0; a_dep = 0; a_span = 0; a_s1 = 0; a_s2 = 0; a_s3 = 0;
                m_st = 1;
            end else if (m_st == 1) begin
                a_hold = h_hold; a_ofs = h_ofs; a_dep = h_dep; a_span = h_span;
                a_s1 = h_s1; a_s2 = h_s2; a_s3 = h_s3;
                m_st = (h_en != 0 && h_dep < 2) ? 2 : 0;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R10", int'(out_valid), int'(exp_v));
            if (exp_v)
                for (int ch = 0; ch < NCH; ch++)
                    chk(exp_tag, int'(pix_out[ch*W +: W]), exp_d[ch]);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic send_px(input int v, input int c, input int r, output int o);
        @(negedge clk);
        pix_valid = 1; col = c[0]; row = r[0];
        pix_in = {W'(v + 3), W'(v ^ 12'h010), W'(v)};
        @(negedge clk);
        pix_valid = 0;
        o = int'(pix_out[W-1:0]);
    endtask

    task automatic sof_pulse();
        @(negedge clk); sof = 1;
        @(negedge clk); sof = 0;
    endtask

    task automatic set_fields(input int en, hold, ofs, dep, span, q1, q2, q3);
        cfg_en = en[0]; cfg_hold = hold[0]; cfg_ofs = ofs[1:0]; cfg_depth = dep[1:0];
        cfg_span = span[0]; s1 = q1[1:0]; s2 = q2[1:0]; s3 = q3[1:0];
    endtask

    task automatic cfg_apply(input int en, hold, ofs, dep, span, q1, q2, q3);
        @(negedge clk);
        set_fields(en, hold, ofs, dep, span, q1, q2, q3);
        cfg_load = 1;
        @(negedge clk); cfg_load = 0;
        @(negedge clk);
    endtask

    task automatic mean4(input string rq, input int v, input int c, input int r,
                         input int k, input int span, input bit active);
        int d, t, q, mx, sum, o, es;
        d = W - k; t = v >> d; mx = (1 << k) - 1;
        q = span ? ((v >> (d - 2)) & 3) : (((v >> (d - 1)) & 1) * 2);
        es = (!active || t == mx) ? 4 * t : 4 * t + q;
        sum = 0;
        for (int f = 0; f < 4; f++) begin
            sof_pulse();
            send_px(v, c, r, o);
            sum += o >> d;
        end
        chk(rq, sum, es);
    endtask

    // ---------------- directed sequence ----------------
    initial begin
        int o;
        int half_exp [4] = '{12'h130, 12'h130, 12'h120, 12'h120};
        repeat (3) @(negedge clk);
        chk("R1 valid low in reset", int'(out_valid), 0);
        rst_n = 1;
        send_px(12'hABC, 0, 0, o);
        chk("R1 6-bit truncation", o, 12'hA80);
        @(negedge clk);
        chk("R10 valid drops", int'(out_valid), 0);

        // R2: pixel in the CLEAR cycle sees cleared settings
        @(negedge clk);
        set_fields(1, 1, 0, 1, 1, 0, 0, 0);
        cfg_load = 1;
        @(negedge clk);
        cfg_load = 0; pix_valid = 1; col = 0; row = 0; pix_in = {3{12'h12C}};
        @(negedge clk);
        pix_valid = 0;
        chk("R2 cleared in CLEAR", int'(pix_out[W-1:0]), 12'h100);

        // R5 patterns with counter held at zero
        send_px(12'h12C, 0, 0, o);
        chk("R5 q3 sel0 phase0 off", o, 12'h120);
        send_px(12'h124, 0, 0, o);
        chk("R5 q1 sel0 phase0 on", o, 12'h130);
        sof_pulse(); sof_pulse();
        send_px(12'h124, 0, 0, o);
        chk("R7 hold keeps phase", o, 12'h130);

        // R6 / R7 counter stepping and pixel parity
        cfg_apply(1, 0, 0, 1, 1, 0, 0, 0);
        send_px(12'h124, 1, 0, o);
        chk("R6 column parity", o, 12'h120);
        send_px(12'h124, 0, 1, o);
        chk("R6 row parity", o, 12'h120);
        sof_pulse();
        send_px(12'h124, 1, 0, o);
        chk("R7 step after pulse", o, 12'h130);
        sof_pulse();
        send_px(12'h124, 0, 1, o);
        chk("R6 count 2 row 1", o, 12'h130);

        cfg_apply(1, 1, 1, 1, 1, 1, 0, 0);
        send_px(12'h124, 0, 0, o);
        chk("R6 offset shifts phase", o, 12'h130);

        // R5 half level, mask 0011
        cfg_apply(1, 1, 0, 1, 1, 0, 2, 0);
        cfg_apply(1, 0, 0, 1, 1, 0, 2, 0);
        for (int f = 0; f < 4; f++) begin
            if (f != 0) sof_pulse();
            send_px(12'h128, 0, 0, o);
            chk("R5 half pattern", o, half_exp[f]);
        end

        // R9 means, several patterns and positions
        mean4("R9 q3", 12'h12C, 0, 0, 8, 1, 1);
        mean4("R9 q1", 12'h124, 1, 1, 8, 1, 1);
        mean4("R9 q2", 12'h128, 1, 0, 8, 1, 1);
        cfg_apply(1, 0, 3, 1, 1, 3, 1, 2);
        mean4("R9 other selects", 12'h3AE, 0, 1, 8, 1, 1);

        // R4 span
        cfg_apply(1, 0, 0, 0, 0, 0, 0, 0);
        mean4("R4 span0 top bit set", 12'h07F, 0, 0, 6, 0, 1);
        mean4("R4 span0 top bit clear", 12'h05F, 1, 0, 6, 0, 1);
        cfg_apply(1, 0, 0, 0, 1, 2, 3, 1);
        mean4("R4 span1 quarters", 12'h07F, 0, 0, 6, 1, 1);

        // R8 saturation
        send_px(12'hFFF, 0, 0, o);
        chk("R8 saturate", o, 12'hFC0);
        mean4("R8 saturate mean", 12'hFFF, 1, 1, 6, 1, 1);

        // R3 refusal at 10 bits and when disabled
        cfg_apply(1, 0, 0, 2, 1, 0, 0, 0);
        for (int f = 0; f < 4; f++) begin
            sof_pulse();
            send_px(12'h7FF, f % 2, 0, o);
            chk("R3 depth2 truncates", o, 12'h7FC);
        end
        cfg_apply(1, 0, 0, 3, 1, 0, 0, 0);
        mean4("R3 depth3 truncates", 12'h7FF, 0, 0, 10, 1, 0);
        cfg_apply(0, 0, 0, 1, 1, 0, 0, 0);
        for (int f = 0; f < 4; f++) begin
            sof_pulse();
            send_px(12'h12C, 0, 0, o);
            chk("R3 disabled truncates", o, 12'h120);
        end

        repeat (2) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule